// File: doc/BRIEF.md
# Quadrature Sample Output Formatter

This block sits between a sine/cosine generator and a pair of DACs. On every clock it receives one signed sine sample and one signed cosine sample, optionally converts both to offset binary by flipping the sign bit, and drives them out of a per-channel output register. In parallel mode the whole word appears on the output bus and is refreshed every clock.

In serial mode each channel sends its word one bit per clock on two output pins at once. The top output bit carries the word most significant bit first. The bottom output bit carries the same word least significant bit first. The middle output bits are held at zero. A capture is requested by pulling the phase-accumulator enable low. While that enable stays high after a capture, the word shifts out. An active-low DAC strobe marks the clock in which the first bit of a new word is present. The mode, format and enable inputs all pass through one register stage before they act.

Top module: `iq_sample_shaper`

## Requirements
- R1: While reset is asserted, and right after it, both output buses are zero and the strobe is high. The control stage resets to parallel mode with two's-complement output and the enable inactive.
- R2: When the registered format input is low, bit 15 of both sine and cosine is inverted, which converts two's complement to offset binary. When it is high, the samples pass unchanged.
- R3: When the registered mode input is high (parallel), both output buses show the formatted input samples one clock after they are presented, reload on every clock, and never shift.
- R4: A change on the mode or format input reaches the outputs one clock later than a change on the sample inputs. A format change is not seen in the first output update after it and is seen in the second.
- R5: In serial mode (registered mode input low), each clock in which the registered enable is low loads the formatted samples into both shift registers. On the clock after the first load, output bit 15 equals sample bit 15 and output bit 0 equals sample bit 0. Output bits 14 to 1 read zero in serial mode.
- R6: In serial mode, each clock with the registered enable high moves the next bit out. Bit 15 carries the word MSB first, and bit 0 carries the same word LSB first, so sixteen consecutive samples rebuild the whole word on each pin.
- R7: The strobe is low in serial mode only while the first bit of a freshly loaded word is at the outputs. Once shifting has started it stays low for exactly one clock, and it stays high in parallel mode.
- R8: After sixteen bits have been presented, shifting stops. Both output buses read zero and stay unchanged until the next capture.
- R9: A capture request that arrives during shifting abandons the current word. The new sample's first bit and a low strobe appear exactly as after a capture from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sin_in | input | 16 | Sine sample, two's complement |
| cos_in | input | 16 | Cosine sample, two's complement |
| acc_en_n | input | 1 | Phase-accumulator enable, active low; low requests a serial capture |
| par_sel | input | 1 | Mode select: 1 parallel, 0 serial |
| fmt_twos | input | 1 | Format select: 1 two's complement, 0 offset binary |
| sin_out | output | 16 | Sine output bus (serial: bit 15 MSB-first, bit 0 LSB-first) |
| cos_out | output | 16 | Cosine output bus (serial: bit 15 MSB-first, bit 0 LSB-first) |
| dac_strobe_n | output | 1 | Active-low first-bit marker in serial mode |

## Verification
A wrong bit counter shows at the ports within one word. It can cause a strobe that lasts longer than one clock, a bit stream that stops short of or runs past sixteen bits, or outputs that keep changing after the word should have ended. A fault in the two shift directions shows as a rebuilt MSB-first or LSB-first word that does not match the sample, seen at the end of that word. A wrong number of control-register stages shows in the first one or two output updates after a mode or format change. A capture that fails to abort is visible on the clock right after the repeated enable.

// File: rtl/iqf_pkg.sv
package iqf_pkg;
   localparam int unsigned IQF_DEF_W = 16;
   localparam int unsigned IQF_LANES = 2;

   typedef enum logic [1:0] {
      LANE_HOLD  = 2'd0,
      LANE_LOAD  = 2'd1,
      LANE_SHIFT = 2'd2
   } lane_act_e;
endpackage

// File: rtl/iqf_ctrl_sync.sv
module iqf_ctrl_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic par_sel,
   input  logic fmt_twos,
   input  logic acc_en_n,
   output logic par_q,
   output logic fmt_q,
   output logic acc_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par_q <= 1'b1;
         fmt_q <= 1'b1;
         acc_q <= 1'b1;
      end else begin
         par_q <= par_sel;
         fmt_q <= fmt_twos;
         acc_q <= acc_en_n;
      end
   end
endmodule

// File: rtl/iqf_fmt_conv.sv
module iqf_fmt_conv #(
   parameter int unsigned W            = 16,
   parameter bit          SIGN_FLIP_EN = 1'b1
) (
   input  logic         fmt_q,
   input  logic [W-1:0] smp_in,
   output logic [W-1:0] smp_out
);
   initial begin
      if (W < 2) $error("iqf_fmt_conv: W must be at least 2");
   end

   generate
      if (SIGN_FLIP_EN) begin : g_flip
         assign smp_out = {smp_in[W-1] ^ ~fmt_q, smp_in[W-2:0]};
      end else begin : g_pass
         logic unused_fmt;
         assign unused_fmt = fmt_q;
         assign smp_out    = smp_in;
      end
   endgenerate
endmodule

// File: rtl/iqf_seq.sv
module iqf_seq
   import iqf_pkg::*;
#(
   parameter int unsigned W     = 16,
   parameter int unsigned CNT_W = $clog2(W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             par_q,
   input  logic             acc_q,
   output lane_act_e        act,
   output logic [CNT_W-1:0] idx,
   output logic             strobe_n
);
   localparam logic [CNT_W-1:0] IDX_END = CNT_W'(W);

   always_comb begin
      if (par_q || !acc_q) act = LANE_LOAD;
      else if (idx < IDX_END) act = LANE_SHIFT;
      else act = LANE_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= IDX_END;
      end else if (par_q) begin
         idx <= IDX_END;
      end else if (!acc_q) begin
         idx <= '0;
      end else if (idx < IDX_END) begin
         idx <= idx + 1'b1;
      end
   end

   assign strobe_n = ~(~par_q && (idx == '0));
endmodule

// File: rtl/iqf_lane.sv
module iqf_lane
   import iqf_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  lane_act_e    act,
   input  logic         par_q,
   input  logic [W-1:0] smp,
   output logic [W-1:0] dout
);
   logic [W-1:0] up_q;
   logic [W-1:0] dn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= '0;
         dn_q <= '0;
      end else begin
         unique case (act)
            LANE_LOAD: begin
               up_q <= smp;
               dn_q <= smp;
            end
            LANE_SHIFT: begin
               up_q <= {up_q[W-2:0], 1'b0};
               dn_q <= {1'b0, dn_q[W-1:1]};
            end
            default: begin
               up_q <= up_q;
               dn_q <= dn_q;
            end
         endcase
      end
   end

   assign dout = par_q ? up_q : {up_q[W-1], {(W-2){1'b0}}, dn_q[0]};
endmodule

// File: rtl/iq_sample_shaper.sv
module iq_sample_shaper
   import iqf_pkg::*;
#(
   parameter int unsigned W            = IQF_DEF_W,
   parameter bit          SIGN_FLIP_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sin_in,
   input  logic [W-1:0] cos_in,
   input  logic         acc_en_n,
   input  logic         par_sel,
   input  logic         fmt_twos,
   output logic [W-1:0] sin_out,
   output logic [W-1:0] cos_out,
   output logic         dac_strobe_n
);
   localparam int unsigned CNT_W = $clog2(W + 1);

   initial begin
      if (W < 2) $error("iq_sample_shaper: W must be at least 2");
   end

   logic             par_q;
   logic             fmt_q;
   logic             acc_q;
   lane_act_e        act;
   logic [CNT_W-1:0] idx;
   logic [W-1:0]     raw  [IQF_LANES];
   logic [W-1:0]     frm  [IQF_LANES];
   logic [W-1:0]     lout [IQF_LANES];

   assign raw[0] = sin_in;
   assign raw[1] = cos_in;

   iqf_ctrl_sync u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .par_sel  (par_sel),
      .fmt_twos (fmt_twos),
      .acc_en_n (acc_en_n),
      .par_q    (par_q),
      .fmt_q    (fmt_q),
      .acc_q    (acc_q)
   );

   iqf_seq #(.W(W), .CNT_W(CNT_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .par_q    (par_q),
      .acc_q    (acc_q),
      .act      (act),
      .idx      (idx),
      .strobe_n (dac_strobe_n)
   );

   generate
      for (genvar ch = 0; ch < IQF_LANES; ch++) begin : g_ch
         iqf_fmt_conv #(.W(W), .SIGN_FLIP_EN(SIGN_FLIP_EN)) u_fmt (
            .fmt_q   (fmt_q),
            .smp_in  (raw[ch]),
            .smp_out (frm[ch])
         );
         iqf_lane #(.W(W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (act),
            .par_q (par_q),
            .smp   (frm[ch]),
            .dout  (lout[ch])
         );
      end
   endgenerate

   assign sin_out = lout[0];
   assign cos_out = lout[1];
endmodule

// File: rtl/iqf_chk.sv
module iqf_chk #(
   parameter int unsigned W     = 16,
   parameter int unsigned CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [W-1:0]     sin_in,
   input logic [W-1:0]     sin_out,
   input logic [W-1:0]     cos_out,
   input logic             par_sel,
   input logic             acc_en_n,
   input logic             dac_strobe_n,
   input logic             par_q,
   input logic             acc_q,
   input logic [CNT_W-1:0] idx
);
   // R1: strobe inactive while held in reset
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_strobe: assert (dac_strobe_n && sin_out == '0 && cos_out == '0);
      end
   end

   // R3: parallel mode follows the sample bus one clock later
   a_r3_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
      par_q && par_sel |=> sin_out[W-2:0] == $past(sin_in[W-2:0]));

   // R7: strobe never low when parallel mode has been held
   a_r7_strobe_par_high: assert property (@(posedge clk) disable iff (!rst_n)
      par_sel && $past(par_sel) |=> dac_strobe_n);

   // R7: once shifting runs, strobe low lasts one clock
   a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_strobe_n && acc_q && !par_sel |=> dac_strobe_n);

   // R8: after the last bit the outputs freeze
   a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !par_q && acc_q && idx == CNT_W'(W) && !par_sel && acc_en_n
      |=> $stable(sin_out) && $stable(cos_out));
endmodule

bind iq_sample_shaper iqf_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sin_in       (sin_in),
   .sin_out      (sin_out),
   .cos_out      (cos_out),
   .par_sel      (par_sel),
   .acc_en_n     (acc_en_n),
   .dac_strobe_n (dac_strobe_n),
   .par_q        (par_q),
   .acc_q        (acc_q),
   .idx          (idx)
);

// File: tb/sim_iq_sample_shaper.sv
module sim_iq_sample_shaper;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] sin_in, cos_in;
   logic        acc_en_n, par_sel, fmt_twos;
   logic [15:0] sin_out, cos_out;
   logic        dac_strobe_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   iq_sample_shaper u0 (
      .clk(clk), .rst_n(rst_n), .sin_in(sin_in), .cos_in(cos_in),
      .acc_en_n(acc_en_n), .par_sel(par_sel), .fmt_twos(fmt_twos),
      .sin_out(sin_out), .cos_out(cos_out), .dac_strobe_n(dac_strobe_n)
   );

   // {fmt, sin, cos, expected sin, expected cos}
   localparam logic [64:0] VEC [6] = '{
      {1'b1, 16'h1234, 16'hFEDC, 16'h1234, 16'hFEDC},
      {1'b0, 16'h1234, 16'hFEDC, 16'h9234, 16'h7EDC},
      {1'b0, 16'h8000, 16'h7FFF, 16'h0000, 16'hFFFF},
      {1'b1, 16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF},
      {1'b0, 16'h0000, 16'hFFFF, 16'h8000, 16'h7FFF},
      {1'b1, 16'hA5A5, 16'h5A5A, 16'hA5A5, 16'h5A5A}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   logic [15:0] ms, ls, mc, lc;
   int          lows;
   logic        strobe0, mid0;

   task automatic serial_word(input logic [15:0] s, input logic [15:0] c);
      @(negedge clk); sin_in = s; cos_in = c; acc_en_n = 1'b0;
      @(negedge clk); acc_en_n = 1'b1;
      lows = 0;
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         ms[15-k] = sin_out[15]; ls[k] = sin_out[0];
         mc[15-k] = cos_out[15]; lc[k] = cos_out[0];
         if (!dac_strobe_n) lows++;
         if (k == 0) begin
            strobe0 = dac_strobe_n;
            mid0    = (sin_out[14:1] == '0) && (cos_out[14:1] == '0);
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; sin_in = 16'h7777; cos_in = 16'h3333;
      acc_en_n = 1'b1; par_sel = 1'b1; fmt_twos = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 reset strobe", 32'(dac_strobe_n), 32'd1);
      check("R1 reset outputs", {sin_out, cos_out}, 32'd0);
      rst_n = 1'b1;

      // R2 R3 R4: parallel table walk
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         fmt_twos = VEC[i][64]; sin_in = VEC[i][63:48]; cos_in = VEC[i][47:32];
         @(negedge clk); @(negedge clk);
         check($sformatf("R2 R3 vector %0d", i), {sin_out, cos_out}, VEC[i][31:0]);
         check("R7 strobe high in parallel", 32'(dac_strobe_n), 32'd1);
      end

      // R3: reload every clock
      @(negedge clk); fmt_twos = 1'b1; sin_in = 16'h0101; cos_in = 16'h0202;
      @(negedge clk); sin_in = 16'h0303;
      check("R3 first update", {sin_out, cos_out}, 32'h01010202);
      @(negedge clk);
      check("R3 next clock reload", {sin_out, cos_out}, 32'h03030202);

      // R4: format change latency
      @(negedge clk); sin_in = 16'h0001; fmt_twos = 1'b1;
      @(negedge clk); fmt_twos = 1'b0;
      @(negedge clk);
      check("R4 format not yet applied", 32'(sin_out), 32'h0001);
      @(negedge clk);
      check("R4 format applied", 32'(sin_out), 32'h8001);

      // switch to serial, two's complement
      @(negedge clk); fmt_twos = 1'b1; par_sel = 1'b0;
      repeat (3) @(negedge clk);
      check("R7 strobe high when serial idle", 32'(dac_strobe_n), 32'd1);

      serial_word(16'hB38E, 16'h4C71);
      check("R5 first strobe low", 32'(strobe0), 32'd0);
      check("R5 middle bits zero", 32'(mid0), 32'd1);
      check("R6 sin MSB-first stream", 32'(ms), 32'hB38E);
      check("R6 sin LSB-first stream", 32'(ls), 32'hB38E);
      check("R6 cos MSB-first stream", 32'(mc), 32'h4C71);
      check("R6 cos LSB-first stream", 32'(lc), 32'h4C71);
      check("R7 single strobe per word", 32'(lows), 32'd1);
      @(negedge clk);
      check("R8 outputs zero after word", {sin_out, cos_out}, 32'd0);
      sin_in = 16'hFFFF; cos_in = 16'hFFFF;
      repeat (3) @(negedge clk);
      check("R8 outputs stay stopped", {sin_out, cos_out}, 32'd0);
      check("R8 strobe stays high", 32'(dac_strobe_n), 32'd1);

      // R2 in serial: offset binary
      @(negedge clk); fmt_twos = 1'b0;
      @(negedge clk);
      serial_word(16'h1357, 16'hF00D);
      check("R2 serial offset sin", 32'(ms), 32'h9357);
      check("R2 serial offset cos", 32'(lc), 32'h700D);

      // R9: abort mid-word
      @(negedge clk); fmt_twos = 1'b1;
      @(negedge clk); sin_in = 16'h0000; cos_in = 16'h0000; acc_en_n = 1'b0;
      @(negedge clk); acc_en_n = 1'b1;
      repeat (6) @(negedge clk);
      sin_in = 16'h8001; cos_in = 16'h8001; acc_en_n = 1'b0;
      @(negedge clk); acc_en_n = 1'b1;
      @(negedge clk);
      check("R9 restart first bits", {sin_out[15], sin_out[0], cos_out[15], cos_out[0]}, 32'hF);
      check("R9 restart strobe low", 32'(dac_strobe_n), 32'd0);
      @(negedge clk);
      check("R9 second bits", {sin_out[15], sin_out[0]}, 32'd0);

      // R1: reset mid-word
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset mid-serial", {15'd0, dac_strobe_n, sin_out}, {15'd0, 1'b1, 16'd0});
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule